// File: doc/BRIEF.md
# Subword-parallel processor core

This block is a small load/store processor with three 16-bit general registers. It reads 18-bit instruction words from an external instruction memory and moves 16-bit words to and from an external data memory. Both memories answer on the falling clock edge. The core runs a simple two-step sequencer: a fetch cycle latches the instruction word, and an execute cycle drives the data-memory strobes and retires the instruction. Every instruction therefore takes exactly two clock cycles.

Arithmetic can treat a register as one 16-bit lane, two 8-bit lanes or four 4-bit lanes, and carries never cross a lane edge. That work is done by a separate partitioned ALU under the core. The core also provides:
- register set with immediate replication into each lane;
- a hardware loop counter with a count-dependent backward jump;
- a halt instruction that raises a done flag until the next reset.

Both memory ports are plain strobed ports with a fixed response time. There is no stall and no back-pressure, so they carry no valid/ready handshake.

Top module: `spw_core`

## Requirements
- R1: Reset (active high) clears the program counter to 0, drops done and holds both strobes low. After reset each instruction takes one fetch cycle, in which both strobes are low and the instruction address is stable, then one execute cycle. The address then moves to the next instruction.
- R2: Opcodes 100110, 100111 and 101000 (16, 8 and 4-bit views) all copy the full memory word at the address in bits [9:0] into the register selected by [11:10]. During their execute cycle the read strobe is high and the write strobe is low.
- R3: Opcodes 101001, 101010 and 101011 write the register selected by [11:10] to the address in bits [9:0]. They raise the read strobe and the write strobe together for exactly one cycle.
- R4: Set opcodes fill the register selected by [11:10] from the 10-bit immediate. 101100 zero-extends it. 101101 copies bits [7:0] into both bytes. 101110 copies bits [3:0] into all four nibbles.
- R5: For opcodes 0 to 35 the function is opcode/3, in the order add, add-immediate, sub, sub-immediate, mul, mul-immediate, mac, shift-left, shift-right, and, or, not. The lane width is opcode mod 3: 0 gives 16 bits, 1 gives 8 bits, 2 gives 4 bits. Register forms compute dst = dst op src, with dst in [3:2] and src in [1:0]. Add and sub wrap inside each lane.
- R6: Immediate forms (add, sub and mul) use the register in [11:10] as both operand and destination. The second operand is the immediate replicated per lane, as for set.
- R7: Shifts and not act on the register in [1:0]. Shifts move by one bit inside each lane and fill with zero.
- R8: MAC computes, per lane, [5:4] = [5:4] + [3:2] * [1:0], with the product truncated to the lane width.
- R9: And and or are bitwise on the whole register, whatever the lane width.
- R10: Opcode 100101 loads the loop counter from the immediate. Opcode 100100 handles the counter as follows:
  - if the counter is nonzero, it decrements the counter and jumps to the immediate instruction address;
  - if the counter is zero, it falls through and the counter stays zero.
- R11: Opcode 111111 raises done. From then until reset, done stays high, the instruction address holds and no strobe is raised.
- R12: An opcode outside those listed does nothing but advance the program counter. Register select 3 names no register: writes to it are dropped and it reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the core acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_addr | output | 10 | Instruction address (program counter) |
| instr_word | input | 18 | Instruction word returned for instr_addr |
| mem_addr | output | 10 | Data-memory word address |
| mem_rd | output | 1 | Data access strobe (high for read and write) |
| mem_wr | output | 1 | Write qualifier; a write needs mem_rd high too |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data returned for mem_addr |
| done | output | 1 | High once a halt has executed |

## Verification
One program is run twice with a reset between the runs. It mixes operand values chosen so that the lane widths give different results:
- An 8-bit add of 0xFFFF and 0x0014 must give 0xFF13. A 16-bit add would give 0x0013.
- A 4-bit subtract of 0xAAAA from 0x0014 must give 0x667A, not 0x556A.
- Byte shifts and nibble shifts catch any bit that leaks across a lane edge.
- Loop runs count the stores inside the body, which tells apart a jump on the pre-decrement count, a jump on the post-decrement count and a counter that wraps below zero.
- A loopjump at count zero pointing at the halt, an unknown opcode, and a set and a store using register select 3 each show up as a missing or altered store.
- A store placed after the halt must never appear.

// File: rtl/spw_pkg.sv
`timescale 1ns/1ps
package spw_pkg;
  localparam int DATA_W  = 16;
  localparam int INSTR_W = 18;
  localparam int IMM_W   = 10;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {LANE16 = 2'd0, LANE8 = 2'd1, LANE4 = 2'd2} lane_e;

  typedef enum logic [3:0] {
    AO_ADD, AO_SUB, AO_MUL, AO_MAC, AO_SHL, AO_SHR, AO_AND, AO_OR, AO_NOT
  } aluop_e;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_LOAD, K_STORE, K_SET, K_SETLOOP, K_LOOPJ, K_HALT
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    aluop_e             aluop;
    lane_e              lane;
    logic               use_imm;
    logic [SEL_W-1:0]   dst;
    logic [SEL_W-1:0]   a;
    logic [SEL_W-1:0]   b;
    logic [SEL_W-1:0]   c;
    logic [IMM_W-1:0]   imm;
  } dec_t;

  // Spread the immediate across the lanes of a data word.
  function automatic logic [DATA_W-1:0] spw_rep(input logic [IMM_W-1:0] imm,
                                                 input lane_e ln);
    case (ln)
      LANE16:  spw_rep = {{(DATA_W-IMM_W){1'b0}}, imm};
      LANE8:   spw_rep = {2{imm[7:0]}};
      default: spw_rep = {4{imm[3:0]}};
    endcase
  endfunction
endpackage

// File: rtl/spw_decode.sv
`timescale 1ns/1ps
module spw_decode
  import spw_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [5:0] op;
  assign op = instr[17:12];

  always_comb begin
    int q;
    int r;
    dec = '0;
    dec.kind  = K_NOP;
    dec.aluop = AO_ADD;
    dec.lane  = LANE16;
    dec.imm   = instr[9:0];
    q = int'(op) / 3;
    r = int'(op) % 3;
    if (op < 6'd36) begin
      dec.kind = K_ALU;
      dec.lane = lane_e'(r[1:0]);
      case (q)
        0, 1:    dec.aluop = AO_ADD;
        2, 3:    dec.aluop = AO_SUB;
        4, 5:    dec.aluop = AO_MUL;
        6:       dec.aluop = AO_MAC;
        7:       dec.aluop = AO_SHL;
        8:       dec.aluop = AO_SHR;
        9:       dec.aluop = AO_AND;
        10:      dec.aluop = AO_OR;
        default: dec.aluop = AO_NOT;
      endcase
      if (q == 1 || q == 3 || q == 5) begin
        dec.use_imm = 1'b1;
        dec.dst     = instr[11:10];
        dec.a       = instr[11:10];
      end else if (q == 6) begin
        dec.dst = instr[5:4];
        dec.c   = instr[5:4];
        dec.a   = instr[3:2];
        dec.b   = instr[1:0];
      end else if (q == 7 || q == 8 || q == 11) begin
        dec.dst = instr[1:0];
        dec.a   = instr[1:0];
      end else begin
        dec.dst = instr[3:2];
        dec.a   = instr[3:2];
        dec.b   = instr[1:0];
      end
    end else begin
      dec.dst = instr[11:10];
      dec.a   = instr[11:10];
      case (op)
        6'd36:              dec.kind = K_LOOPJ;
        6'd37:              dec.kind = K_SETLOOP;
        6'd38, 6'd39, 6'd40: begin
          dec.kind = K_LOAD;
          dec.lane = lane_e'(2'(op - 6'd38));
        end
        6'd41, 6'd42, 6'd43: begin
          dec.kind = K_STORE;
          dec.lane = lane_e'(2'(op - 6'd41));
        end
        6'd44, 6'd45, 6'd46: begin
          dec.kind = K_SET;
          dec.lane = lane_e'(2'(op - 6'd44));
        end
        6'd63:              dec.kind = K_HALT;
        default:            dec.kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/spw_lane_slice.sv
`timescale 1ns/1ps
module spw_lane_slice
  import spw_pkg::*;
#(
  parameter int W = 4
) (
  input  aluop_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  logic [W-1:0] prod;
  assign prod = a * b;

  always_comb begin
    case (op)
      AO_ADD:  y = a + b;
      AO_SUB:  y = a - b;
      AO_MUL:  y = prod;
      AO_MAC:  y = c + prod;
      AO_SHL:  y = {a[W-2:0], 1'b0};
      AO_SHR:  y = {1'b0, a[W-1:1]};
      AO_AND:  y = a & b;
      AO_OR:   y = a | b;
      AO_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/spw_palu.sv
`timescale 1ns/1ps
module spw_palu
  import spw_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  aluop_e        op,
  input  lane_e         lane,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] y
);
  localparam int NVIEW = 3;
  logic [NVIEW-1:0][DW-1:0] res;

  for (genvar g = 0; g < NVIEW; g++) begin : g_view
    localparam int W = DW >> g;
    localparam int N = 1 << g;
    for (genvar l = 0; l < N; l++) begin : g_lane
      spw_lane_slice #(.W(W)) u_slice (
        .op(op),
        .a (a[l*W +: W]),
        .b (b[l*W +: W]),
        .c (c[l*W +: W]),
        .y (res[g][l*W +: W])
      );
    end
  end

  always_comb begin
    case (lane)
      LANE8:   y = res[1];
      LANE4:   y = res[2];
      default: y = res[0];
    endcase
  end
endmodule

// File: rtl/spw_regfile.sv
`timescale 1ns/1ps
module spw_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 3,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [DW-1:0]   wdata,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  input  logic [SELW-1:0] sel_c,
  output logic [DW-1:0]   rd_a,
  output logic [DW-1:0]   rd_b,
  output logic [DW-1:0]   rd_c
);
  logic [NREG-1:0][DW-1:0] regs;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              regs[r] <= '0;
      else if (we && wsel == SELW'(r))      regs[r] <= wdata;
    end
  end

  // Selects with no register behind them read as zero.
  always_comb begin
    rd_a = '0;
    rd_b = '0;
    rd_c = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel_a == SELW'(r)) rd_a = regs[r];
      if (sel_b == SELW'(r)) rd_b = regs[r];
      if (sel_c == SELW'(r)) rd_c = regs[r];
    end
  end

  p_ghost_write_r12: assert property (@(posedge clk) disable iff (rst)
    (we && int'(wsel) >= NREG) |=> $stable(regs));
endmodule

// File: rtl/spw_core.sv
`timescale 1ns/1ps
module spw_core
  import spw_pkg::*;
#(
  parameter int AW   = 10,
  parameter int LCW  = 10,
  parameter int NREG = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      instr_addr,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done
);
  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_e;

  state_e              state;
  logic [AW-1:0]       pc;
  logic [LCW-1:0]      lc;
  logic [INSTR_W-1:0]  ir;
  dec_t                dec;
  logic                exec;
  logic [DATA_W-1:0]   rd_a, rd_b, rd_c, opnd_b, rep, alu_y;
  logic                rf_we;
  logic [DATA_W-1:0]   rf_wdata;

  spw_decode u_dec (.instr(ir), .dec(dec));

  assign exec   = (state == S_EXEC);
  assign rep    = spw_rep(dec.imm, dec.lane);
  assign opnd_b = dec.use_imm ? rep : rd_b;

  spw_regfile #(.DW(DATA_W), .NREG(NREG), .SELW(SEL_W)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wsel(dec.dst), .wdata(rf_wdata),
    .sel_a(dec.a), .sel_b(dec.b), .sel_c(dec.c),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c)
  );

  spw_palu #(.DW(DATA_W)) u_alu (
    .op(dec.aluop), .lane(dec.lane), .a(rd_a), .b(opnd_b), .c(rd_c), .y(alu_y)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_y;
    case (dec.kind)
      K_ALU:  rf_we = exec;
      K_LOAD: begin rf_we = exec; rf_wdata = mem_rdata; end
      K_SET:  begin rf_we = exec; rf_wdata = rep;       end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      lc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= instr_word;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          pc    <= pc + AW'(1);
          case (dec.kind)
            K_SETLOOP: lc <= LCW'(dec.imm);
            K_LOOPJ: begin
              if (lc != '0) begin
                lc <= lc - LCW'(1);
                pc <= AW'(dec.imm);
              end
            end
            K_HALT: begin
              state <= S_HALT;
              pc    <= pc;
            end
            default: ;
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign instr_addr = pc;
  assign mem_addr   = AW'(dec.imm);
  assign mem_rd     = exec && (dec.kind == K_LOAD || dec.kind == K_STORE);
  assign mem_wr     = exec && (dec.kind == K_STORE);
  assign mem_wdata  = rd_a;
  assign done       = (state == S_HALT);

  p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_rd);
  p_fetch_holds_pc_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> $stable(instr_addr));
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_halt_pc_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(instr_addr));
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_rd && !mem_wr));
  p_lc_never_up_r10: assert property (@(posedge clk) disable iff (rst)
    !(exec && dec.kind == K_SETLOOP) |=> (lc <= $past(lc)));
  p_jump_target_r10: assert property (@(posedge clk) disable iff (rst)
    (exec && dec.kind == K_LOOPJ && lc != '0) |=> (instr_addr == $past(AW'(dec.imm))));
endmodule

// File: tb/sim_spw_core.sv
`timescale 1ns/1ps
module sim_spw_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  instr_addr;
  logic [17:0] instr_word = '0;
  logic [9:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        done;

  always #4 clk = ~clk;

  spw_core u0 (
    .clk(clk), .rst(rst), .instr_addr(instr_addr), .instr_word(instr_word),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  localparam int NPROG = 42;
  localparam logic [17:0] PROG [NPROG] = '{
    18'b100110_00_0000000000, // 0  R2 load16 R0 <- [0]
    18'b100111_01_0000000001, // 1  R2 load8  R1 <- [1]
    18'b101000_10_0000000010, // 2  R2 load4  R2 <- [2]
    18'b000000_00000000_00_01, // 3  R5 add16 R0 += R1
    18'b101001_00_0000001000, // 4  R3 store [8]
    18'b101010_01_0000001001, // 5  store [9]
    18'b101011_10_0000001010, // 6  store [10]
    18'b101101_10_0011111111, // 7  R4 set8 R2 = 0xFFFF
    18'b000001_00000000_10_00, // 8  R5 add8 R2 += R0
    18'b101001_10_0000001011, // 9  store [11]
    18'b101110_01_0001011010, // 10 R4 set4 R1 = 0xAAAA
    18'b001000_00000000_00_01, // 11 R5 sub4 R0 -= R1
    18'b101001_00_0000001100, // 12 store [12]
    18'b101100_01_1111111111, // 13 set16 R1 = 0x03FF
    18'b010110_0000000000_01, // 14 R7 shl8 R1
    18'b011010_0000000000_10, // 15 R7 shr4 R2
    18'b100001_0000000000_10, // 16 R7 not16 R2
    18'b101010_01_0000001101, // 17 store [13]
    18'b101011_10_0000001110, // 18 store [14]
    18'b101100_00_0000000011, // 19 set16 R0 = 3
    18'b101110_01_0000000101, // 20 set4 R1 = 0x5555
    18'b101101_10_0000000100, // 21 set8 R2 = 0x0404
    18'b010100_000000_00_01_10, // 22 R8 mac4 R0 += R1*R2
    18'b101001_00_0000001111, // 23 store [15]
    18'b010000_01_0000000011, // 24 R6 muli8 R1 *= 3
    18'b011011_00000000_01_10, // 25 R9 and16 R1 &= R2
    18'b100000_00000000_01_00, // 26 R9 or4 R1 |= R0
    18'b000101_10_0000001111, // 27 R6 addi4 R2 += F
    18'b001001_01_0000001000, // 28 R6 subi16 R1 -= 8
    18'b101001_01_0000010000, // 29 store [16]
    18'b101001_10_0000010001, // 30 store [17]
    18'b100101_00_0000000010, // 31 R10 setloop 2
    18'b000011_00_0000000001, // 32 addi16 R0 += 1
    18'b101001_00_0000010010, // 33 store [18]
    18'b100100_00_0000100000, // 34 R10 loopjump 32
    18'b100100_00_0000101000, // 35 R10 loopjump 40 at count zero
    18'b110000_11_1111111111, // 36 R12 unknown opcode
    18'b101100_11_0101010101, // 37 R12 set to select 3
    18'b101001_00_0000010011, // 38 store [19]
    18'b101001_11_0000010100, // 39 R12 store select 3 to [20]
    18'b111111_000000000000,  // 40 R11 halt
    18'b101001_00_0000010101  // 41 must never run
  };

  // {requirement number, address, data} for each store, in order.
  localparam int NEXP = 15;
  localparam logic [33:0] EXPW [NEXP] = '{
    {8'd5,  10'd8,  16'h0014}, {8'd2,  10'd9,  16'h000F},
    {8'd2,  10'd10, 16'h0004}, {8'd4,  10'd11, 16'hFF13},
    {8'd5,  10'd12, 16'h667A}, {8'd7,  10'd13, 16'h06FE},
    {8'd7,  10'd14, 16'h88FE}, {8'd8,  10'd15, 16'h0407},
    {8'd9,  10'd16, 16'h03FF}, {8'd6,  10'd17, 16'hF3F3},
    {8'd10, 10'd18, 16'h0408}, {8'd10, 10'd18, 16'h0409},
    {8'd10, 10'd18, 16'h040A}, {8'd12, 10'd19, 16'h040A},
    {8'd12, 10'd20, 16'h0000}
  };

  logic [17:0] imem [64];
  logic [15:0] dmem [32];
  int n_checks = 0;
  int n_fail   = 0;
  int widx     = 0;
  int cnt18    = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: both memories answer on the falling edge.
  always @(negedge clk) begin
    instr_word <= imem[instr_addr[5:0]];
    if (mem_rd && mem_wr) begin
      dmem[mem_addr[4:0]] <= mem_wdata;
      if (mem_addr == 10'd18) cnt18++;
      if (widx < NEXP) begin
        check(mem_addr == EXPW[widx][25:16] && mem_wdata == EXPW[widx][15:0],
              $sformatf("R3 store %0d (R%0d)", widx, EXPW[widx][33:26]),
              {6'b0, mem_addr, mem_wdata}, {6'b0, EXPW[widx][25:0]});
      end else begin
        check(1'b0, "R11 store after the expected list", {6'b0, mem_addr, mem_wdata}, 32'h0);
      end
      widx++;
    end else if (mem_rd) begin
      mem_rdata <= dmem[mem_addr[4:0]];
    end
  end

  // Watchdog on the wait for done.
  task automatic wait_done(input string tag);
    int i;
    for (i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    check(done === 1'b1, {"R11 done reached ", tag}, {31'b0, done}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 18'b111111_000000000000;
    for (int i = 0; i < NPROG; i++) imem[i] = PROG[i];
    for (int i = 0; i < 32; i++) dmem[i] = '0;
    dmem[0] = 16'd5;
    dmem[1] = 16'd15;
    dmem[2] = 16'd4;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(instr_addr == 10'd0, "R1 reset pc", {22'b0, instr_addr}, 32'h0);
    check(done == 1'b0, "R1 reset done", {31'b0, done}, 32'h0);
    check(!mem_rd && !mem_wr, "R1 reset strobes", {30'b0, mem_rd, mem_wr}, 32'h0);

    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk); // fetch cycle of instruction 0
    check(!mem_rd && instr_addr == 10'd0, "R1 fetch cycle quiet",
          {21'b0, mem_rd, instr_addr}, 32'h0);
    @(negedge clk); // execute cycle of the load
    check(mem_rd && !mem_wr && mem_addr == 10'd0, "R2 load strobes",
          {20'b0, mem_rd, mem_wr, mem_addr}, {20'b0, 2'b10, 10'd0});
    @(negedge clk);
    check(instr_addr == 10'd1 && !mem_rd, "R1 next instruction",
          {21'b0, mem_rd, instr_addr}, 32'h1);

    wait_done("run 1");
    check(widx == NEXP, "R12 store count run 1", widx, NEXP);
    check(cnt18 == 3, "R10 loop body stores", cnt18, 3);
    check(instr_addr == 10'd40, "R11 halt address", {22'b0, instr_addr}, 32'd40);
    repeat (6) @(negedge clk);
    check(done && instr_addr == 10'd40, "R11 held after halt",
          {21'b0, done, instr_addr}, {21'b0, 1'b1, 10'd40});
    check(!mem_rd && !mem_wr, "R11 no strobes after halt",
          {30'b0, mem_rd, mem_wr}, 32'h0);
    check(widx == NEXP, "R11 no extra store", widx, NEXP);

    // Reset after halt, then run the program again.
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!done && instr_addr == 10'd0, "R1 reset clears halt",
          {21'b0, done, instr_addr}, 32'h0);
    widx  = 0;
    cnt18 = 0;
    @(posedge clk); #1 rst = 1'b0;
    wait_done("run 2");
    check(widx == NEXP, "R10 store count run 2", widx, NEXP);
    check(cnt18 == 3, "R10 loop body stores run 2", cnt18, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule